// File: doc/BRIEF.md
# Table-Driven Pulse Shaper Address Generator

This block forms the address words for two external lookup tables, one per quadrature channel, that hold precomputed shaped-pulse samples. Every symbol strobe it shifts the incoming I and Q symbol values into a short history per channel. Every sample strobe it advances a phase counter that tracks the position inside the current symbol. Each channel's address is its bank bit, its symbol history and the sample phase, side by side. The table therefore needs one entry for each combination of history and phase. It returns the output sample without any arithmetic in this block.

A host register write selects one of two table banks for each channel and turns a bypass path on or off. A bank change is held back until the next symbol boundary, so one symbol's samples always come from a single bank. In bypass, which is the state after reset, the most recent I symbol is presented on a direct converter output to give rectangular pulses. The symbol rate and the sample rate are independent strobes on a common clock. The number of samples per symbol is set by a programmable wrap value.

Top module: `lps_addr_gen`

## Requirements
- R1: While rst_n is low and after its release, bypass_o is 1, both address outputs are 0 and dac_direct is 0.
- R2: Each address is {bank bit at bit 15, symbol history at bits 14:3, sample phase at bits 2:0}. The newest symbol sits at bits 6:3, the previous one at 10:7 and the oldest at 14:11.
- R3: The history of a channel shifts by one symbol only in a cycle with sym_stb high. The oldest entry is discarded. The history is unchanged in every other cycle.
- R4: On sample_stb without sym_stb, the phase goes to 0 if it is at or above sps_m1, and otherwise increases by one.
- R5: sym_stb clears the phase to 0 and takes priority over a sample_stb in the same cycle.
- R6: A bank value written with cfg_wr becomes visible in bit 15 of an address only after the next sym_stb. A write in the same cycle as sym_stb takes effect at that boundary.
- R7: The I bank (cfg_bank_i) and the Q bank (cfg_bank_q) are independent, so the two address outputs can carry different bank bits.
- R8: cfg_bypass written with cfg_wr appears on bypass_o one cycle later, with no wait for a symbol boundary.
- R9: dac_direct equals the I symbol captured at the latest sym_stb while bypass_o is 1, and is 0 while bypass_o is 0.
- R10: When sps_m1 is lowered below the current phase, the next sample_stb wraps the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_stb | input | 1 | Symbol boundary strobe |
| sample_stb | input | 1 | Sample strobe |
| i_sym | input | 4 | I symbol value, taken on sym_stb |
| q_sym | input | 4 | Q symbol value, taken on sym_stb |
| sps_m1 | input | 3 | Samples per symbol minus one |
| cfg_wr | input | 1 | Host control register write |
| cfg_bypass | input | 1 | Bypass select to write |
| cfg_bank_i | input | 1 | I table bank to write |
| cfg_bank_q | input | 1 | Q table bank to write |
| i_addr | output | 16 | I table address |
| q_addr | output | 16 | Q table address |
| bypass_o | output | 1 | Bypass path active |
| dac_direct | output | 4 | Direct converter value in bypass |

## Verification
Two pairs of events can land in one cycle. The first is a symbol strobe together with a sample strobe, where the phase clear has to win. The second is a host bank write together with a symbol strobe, where the new bank has to apply at that very boundary. The bench drives both strobes and the control writes from independent pseudo-random streams, so both coincidences occur many times, and it also forces each one directly. Its behavioural model applies the write first and then resolves the symbol strobe ahead of the sample strobe. Every clock it compares both addresses, the bypass flag and the direct value against that model.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef struct packed {
    logic bypass;
    logic bank_i;
    logic bank_q;
  } lps_cfg_t;

  localparam lps_cfg_t LPS_CFG_RESET = '{bypass: 1'b1, bank_i: 1'b0, bank_q: 1'b0};
endpackage

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  lps_cfg_t cfg_in,
  input  logic     sym_stb,
  output logic     bypass,
  output logic     bank_i,
  output logic     bank_q
);
  lps_cfg_t pend_q, pend_d;
  logic     act_i_q, act_i_d;
  logic     act_q_q, act_q_d;

  // staged copy follows every write; active banks load only at a symbol edge
  always_comb begin
    pend_d  = pend_q;
    if (cfg_wr) pend_d = cfg_in;
    act_i_d = act_i_q;
    act_q_d = act_q_q;
    if (sym_stb) begin
      act_i_d = pend_d.bank_i;
      act_q_d = pend_d.bank_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= LPS_CFG_RESET;
      act_i_q <= LPS_CFG_RESET.bank_i;
      act_q_q <= LPS_CFG_RESET.bank_q;
    end else begin
      pend_q  <= pend_d;
      act_i_q <= act_i_d;
      act_q_q <= act_q_d;
    end
  end

  assign bypass = pend_q.bypass;
  assign bank_i = act_i_q;
  assign bank_q = act_q_q;
endmodule

// File: rtl/lps_hist.sv
module lps_hist #(
  parameter int SYM_W = 4,
  parameter int DEPTH = 3,
  localparam int HIST_W = SYM_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_stb,
  input  logic [SYM_W-1:0]  sym_in,
  output logic [HIST_W-1:0] hist
);
  logic [SYM_W-1:0] stage_q [DEPTH];
  logic [SYM_W-1:0] stage_d [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_comb begin
      stage_d[s] = stage_q[s];
      if (sym_stb) begin
        if (s == 0) stage_d[s] = sym_in;
        else        stage_d[s] = stage_q[(s == 0) ? 0 : s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end

    // newest symbol in the lowest slice
    assign hist[s*SYM_W +: SYM_W] = stage_q[s];
  end
endmodule

// File: rtl/lps_phase.sv
module lps_phase #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sym_stb,
  input  logic            sample_stb,
  input  logic [PH_W-1:0] sps_m1,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (sym_stb)
      ph_d = '0;
    else if (sample_stb)
      ph_d = (ph_q >= sps_m1) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/lps_addr_gen.sv
module lps_addr_gen
  import lps_pkg::*;
#(
  parameter int SYM_W = 4,
  parameter int DEPTH = 3,
  parameter int PH_W  = 3,
  localparam int HIST_W = SYM_W * DEPTH,
  localparam int ADDR_W = 1 + HIST_W + PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_stb,
  input  logic              sample_stb,
  input  logic [SYM_W-1:0]  i_sym,
  input  logic [SYM_W-1:0]  q_sym,
  input  logic [PH_W-1:0]   sps_m1,
  input  logic              cfg_wr,
  input  logic              cfg_bypass,
  input  logic              cfg_bank_i,
  input  logic              cfg_bank_q,
  output logic [ADDR_W-1:0] i_addr,
  output logic [ADDR_W-1:0] q_addr,
  output logic              bypass_o,
  output logic [SYM_W-1:0]  dac_direct
);
  localparam int NCH = 2;

  lps_cfg_t         cfg_in;
  logic             bypass, bank_i, bank_q;
  logic [PH_W-1:0]  phase;
  logic [SYM_W-1:0] ch_sym  [NCH];
  logic [HIST_W-1:0] ch_hist [NCH];
  logic [SYM_W-1:0] dir_q, dir_d;

  assign cfg_in = '{bypass: cfg_bypass, bank_i: cfg_bank_i, bank_q: cfg_bank_q};

  lps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_in(cfg_in),
    .sym_stb(sym_stb), .bypass(bypass), .bank_i(bank_i), .bank_q(bank_q)
  );

  lps_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sample_stb(sample_stb),
    .sps_m1(sps_m1), .phase(phase)
  );

  assign ch_sym[0] = i_sym;
  assign ch_sym[1] = q_sym;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lps_hist #(.SYM_W(SYM_W), .DEPTH(DEPTH)) u_hist (
      .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb),
      .sym_in(ch_sym[c]), .hist(ch_hist[c])
    );
  end

  // direct path register: latest I symbol
  always_comb begin
    dir_d = dir_q;
    if (sym_stb) dir_d = i_sym;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_d;
  end

  assign i_addr     = {bank_i, ch_hist[0], phase};
  assign q_addr     = {bank_q, ch_hist[1], phase};
  assign bypass_o   = bypass;
  assign dac_direct = bypass ? dir_q : '0;
endmodule

// File: rtl/lps_addr_gen_chk.sv
module lps_addr_gen_chk #(
  parameter int SYM_W = 4,
  parameter int DEPTH = 3,
  parameter int PH_W  = 3,
  localparam int ADDR_W = 1 + SYM_W * DEPTH + PH_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_stb,
  input logic              sample_stb,
  input logic [PH_W-1:0]   sps_m1,
  input logic [ADDR_W-1:0] i_addr,
  input logic [ADDR_W-1:0] q_addr,
  input logic              bypass_o,
  input logic [SYM_W-1:0]  dac_direct
);
  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> ($stable(i_addr[ADDR_W-1]) && $stable(q_addr[ADDR_W-1])));

  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> ($stable(i_addr[ADDR_W-2:PH_W]) && $stable(q_addr[ADDR_W-2:PH_W])));

  // R5
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> (i_addr[PH_W-1:0] == '0));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !sym_stb && (i_addr[PH_W-1:0] < sps_m1))
      |=> (i_addr[PH_W-1:0] == $past(i_addr[PH_W-1:0]) + 1'b1));

  // R9
  direct_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_o |-> (dac_direct == '0));
endmodule

bind lps_addr_gen lps_addr_gen_chk #(.SYM_W(SYM_W), .DEPTH(DEPTH), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sample_stb(sample_stb),
  .sps_m1(sps_m1), .i_addr(i_addr), .q_addr(q_addr),
  .bypass_o(bypass_o), .dac_direct(dac_direct)
);

// File: tb/sim_lps_addr_gen.sv
module sim_lps_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_stb = 0, sample_stb = 0, cfg_wr = 0;
  logic cfg_bypass = 0, cfg_bank_i = 0, cfg_bank_q = 0;
  logic [3:0] i_sym = 0, q_sym = 0;
  logic [2:0] sps_m1 = 3'd7;
  logic [15:0] i_addr, q_addr;
  logic bypass_o;
  logic [3:0] dac_direct;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lps_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sample_stb(sample_stb),
    .i_sym(i_sym), .q_sym(q_sym), .sps_m1(sps_m1), .cfg_wr(cfg_wr),
    .cfg_bypass(cfg_bypass), .cfg_bank_i(cfg_bank_i), .cfg_bank_q(cfg_bank_q),
    .i_addr(i_addr), .q_addr(q_addr), .bypass_o(bypass_o), .dac_direct(dac_direct)
  );

  // behavioural reference
  int m_byp, m_pbi, m_pbq, m_bi, m_bq, m_ph, m_dir;
  int hi[$], hq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_byp = 1; m_pbi = 0; m_pbq = 0; m_bi = 0; m_bq = 0; m_ph = 0; m_dir = 0;
      hi = '{0, 0, 0}; hq = '{0, 0, 0};
    end else begin
      if (cfg_wr) begin m_byp = cfg_bypass; m_pbi = cfg_bank_i; m_pbq = cfg_bank_q; end
      if (sym_stb) begin
        m_bi = m_pbi; m_bq = m_pbq;
        hi.push_front(int'(i_sym)); void'(hi.pop_back());
        hq.push_front(int'(q_sym)); void'(hq.pop_back());
        m_dir = i_sym; m_ph = 0;
      end else if (sample_stb) begin
        m_ph = (m_ph >= int'(sps_m1)) ? 0 : m_ph + 1;
      end
    end
  end

  function automatic int addr_of(int b, int h[$], int ph);
    return (b << 15) | (h[2] << 11) | (h[1] << 7) | (h[0] << 3) | ph;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2/R3/R4/R6 i_addr", int'(i_addr), addr_of(m_bi, hi, m_ph));
    chk("R2/R3/R7 q_addr", int'(q_addr), addr_of(m_bq, hq, m_ph));
    chk("R8 bypass_o", int'(bypass_o), m_byp);
    chk("R9 dac_direct", int'(dac_direct), m_byp ? m_dir : 0);
  endtask

  task automatic idle();
    sym_stb = 0; sample_stb = 0; cfg_wr = 0;
  endtask

  task automatic rand_run(int n, int pcfg);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_all();
      sym_stb    = ($urandom_range(0, 7) == 0);
      sample_stb = ($urandom_range(0, 3) != 0);
      i_sym = 4'($urandom); q_sym = 4'($urandom);
      cfg_wr = ($urandom_range(0, 99) < pcfg);
      cfg_bypass = 1'($urandom); cfg_bank_i = 1'($urandom); cfg_bank_q = 1'($urandom);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 i_addr in reset", int'(i_addr), 0);
    chk("R1 bypass in reset", int'(bypass_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q_addr after reset", int'(q_addr), 0);
    chk("R1 dac_direct after reset", int'(dac_direct), 0);
    // R6: bank write without symbol is not visible
    cfg_wr = 1; cfg_bypass = 0; cfg_bank_i = 1; cfg_bank_q = 0;
    @(negedge clk); idle();
    chk("R8 bypass off next cycle", int'(bypass_o), 0);
    repeat (2) @(negedge clk);
    chk("R6 bank held before symbol", int'(i_addr[15]), 0);
    sym_stb = 1; i_sym = 4'h9; q_sym = 4'h5;
    @(negedge clk); idle();
    chk("R6/R7 I bank after symbol", int'(i_addr[15]), 1);
    chk("R7 Q bank independent", int'(q_addr[15]), 0);
    chk("R2 newest I at bits 6:3", int'(i_addr[6:3]), 9);
    // R5: symbol and sample together
    sample_stb = 1; @(negedge clk); sample_stb = 1; @(negedge clk);
    chk("R4 phase stepped", int'(i_addr[2:0]), 2);
    sym_stb = 1; sample_stb = 1; i_sym = 4'h3;
    @(negedge clk); idle();
    chk("R5 symbol wins over sample", int'(i_addr[2:0]), 0);
    chk("R3 history shifted", int'(i_addr[10:3]), 8'h93);
    // R6: write coinciding with symbol applies at that boundary
    cfg_wr = 1; cfg_bypass = 1; cfg_bank_i = 0; cfg_bank_q = 1; sym_stb = 1; i_sym = 4'hC;
    @(negedge clk); idle();
    chk("R6 same-cycle write I bank", int'(i_addr[15]), 0);
    chk("R6 same-cycle write Q bank", int'(q_addr[15]), 1);
    chk("R9 direct value in bypass", int'(dac_direct), 12);
    // R10: lower wrap below current phase
    sps_m1 = 3'd7;
    repeat (5) begin sample_stb = 1; @(negedge clk); end
    idle();
    chk("R4 phase at 5", int'(i_addr[2:0]), 5);
    sps_m1 = 3'd2; sample_stb = 1;
    @(negedge clk); idle();
    chk("R10 wrap after lowered limit", int'(i_addr[2:0]), 0);
    // pseudo-random streams with model comparison every cycle
    sps_m1 = 3'd7; rand_run(3000, 5);
    sps_m1 = 3'd3; rand_run(3000, 10);
    sps_m1 = 3'd0; rand_run(1000, 10);
    sps_m1 = 3'd5; rand_run(3000, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule